// File: doc/BRIEF.md
# Rank-Steered Packet Compactor

The block accepts a vector of lanes each cycle. Every lane carries a valid flag and a payload word. It moves the valid payloads onto the lowest-numbered output lanes, with no gaps and in their original relative order. It also reports how many payloads were valid. Downstream logic can then treat the result as a dense list: entries 0 through k-1 are live and everything above them is empty.

The block works in three steps:
- A logarithmic-depth running-count network gives each valid lane its inclusive count of valid lanes at or below it.
- A decrement step turns that count into a zero-based destination index and clears the index on empty lanes.
- A cascade of two-input exchange stages, one per address bit from bit 0 upward, moves each payload toward its index. At each stage a payload goes to the upper exchange output when the current index bit is 0 and to the lower output otherwise.

Because the indices are consecutive and follow input order, no two payloads ever ask for the same exchange output. Every stage is registered, so a new input vector can be accepted every cycle and results appear after a fixed delay.

Top module: `rank_compactor`

## Requirements
- R1: With k valid input lanes, output lanes 0..k-1 are valid and carry the payloads of the valid input lanes in ascending input-lane order. Lane i's payload occupies bits i*DW+DW-1 down to i*DW of the data buses.
- R2: Output lanes k..LANES-1 show valid 0.
- R3: out_count equals k, the number of valid input lanes.
- R4: Each result appears exactly 2*log2(LANES)+1 clock cycles after its input vector is sampled. A new, independent vector may be presented every cycle.
- R5: An input vector with no valid lanes gives out_valid all zero and out_count 0.
- R6: An input vector with every lane valid passes through unchanged: lane i goes to output lane i, and out_count equals LANES.
- R7: While rst is high at a clock edge, out_valid and out_count become zero after that edge. Vectors already in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | Per-lane valid flags |
| in_data | input | LANES*DW | Per-lane payloads, lane i at bits i*DW +: DW |
| out_valid | output | LANES | Compacted valid flags |
| out_data | output | LANES*DW | Compacted payloads, same lane layout |
| out_count | output | log2(LANES)+1 | Number of valid payloads in this result |

## Verification
A wrong running count or decrement shows up as payloads on the wrong output lanes. It can also show up as a hole or an extra valid flag in the output, or a duplicated or lost payload. All of these appear in the result exactly 2*log2(LANES)+1 cycles after the offending vector. A steering error at one exchange stage affects only vectors whose indices exercise that bit. For that reason the directed patterns include sparse, dense, alternating, single-lane and top-lane cases, plus back-to-back streams that expose any stage that holds or mixes data between cycles.

// File: rtl/cq_pkg.sv
package cq_pkg;

  // Index of the lane with bit 'stage' cleared that forms exchange pair j.
  function automatic int pair_lo(input int j, input int stage);
    int low_mask;
    low_mask = (1 << stage) - 1;
    return ((j >> stage) << (stage + 1)) | (j & low_mask);
  endfunction

endpackage

// File: rtl/cq_prefix_rank.sv
module cq_prefix_rank #(
  parameter int LANES = 8,
  parameter int DW    = 8,
  parameter int LG    = $clog2(LANES),
  parameter int CW    = LG + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES-1:0]      in_valid,
  input  logic [LANES*DW-1:0]   in_data,
  output logic [LANES-1:0]      rank_valid,
  output logic [LANES*DW-1:0]   rank_data,
  output logic [LANES*LG-1:0]   rank_idx,
  output logic [CW-1:0]         rank_count
);

  // Running-count pipeline: level 0 is the raw input, level l+1 is registered.
  logic [LANES-1:0]    vld [LG+1];
  logic [LANES*DW-1:0] dat [LG+1];
  logic [LANES*CW-1:0] cnt [LG+1];
  logic [LANES*CW-1:0] cnt_nxt [LG];

  assign vld[0] = in_valid;
  assign dat[0] = in_data;

  for (genvar i = 0; i < LANES; i++) begin : g_seed
    assign cnt[0][i*CW +: CW] = CW'(in_valid[i]);
  end

  for (genvar l = 0; l < LG; l++) begin : g_level
    localparam int STEP = 1 << l;
    for (genvar i = 0; i < LANES; i++) begin : g_cell
      if (i >= STEP) begin : g_add
        assign cnt_nxt[l][i*CW +: CW] = cnt[l][i*CW +: CW] + cnt[l][(i-STEP)*CW +: CW];
      end else begin : g_pass
        assign cnt_nxt[l][i*CW +: CW] = cnt[l][i*CW +: CW];
      end
    end

    always_ff @(posedge clk) begin
      dat[l+1] <= dat[l];
      if (rst) begin
        vld[l+1] <= '0;
        cnt[l+1] <= '0;
      end else begin
        vld[l+1] <= vld[l];
        cnt[l+1] <= cnt_nxt[l];
      end
    end
  end

  // Decrement stage: inclusive count -> zero-based index, cleared on empty lanes.
  logic [LANES*LG-1:0] idx_nxt;
  for (genvar i = 0; i < LANES; i++) begin : g_sub
    logic [CW-1:0] dec;
    assign dec = cnt[LG][i*CW +: CW] - CW'(1);
    assign idx_nxt[i*LG +: LG] = vld[LG][i] ? dec[LG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    rank_data <= dat[LG];
    if (rst) begin
      rank_valid <= '0;
      rank_idx   <= '0;
      rank_count <= '0;
    end else begin
      rank_valid <= vld[LG];
      rank_idx   <= idx_nxt;
      rank_count <= cnt[LG][(LANES-1)*CW +: CW];
    end
  end

endmodule

// File: rtl/cq_cube_stage.sv
module cq_cube_stage #(
  parameter int LANES = 8,
  parameter int DW    = 8,
  parameter int LG    = $clog2(LANES),
  parameter int CW    = LG + 1,
  parameter int STAGE = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    in_v,
  input  logic [LANES*DW-1:0] in_d,
  input  logic [LANES*LG-1:0] in_r,
  input  logic [CW-1:0]       in_cnt,
  output logic [LANES-1:0]    out_v,
  output logic [LANES*DW-1:0] out_d,
  output logic [LANES*LG-1:0] out_r,
  output logic [CW-1:0]       out_cnt
);

  logic [LANES-1:0]    nxt_v;
  logic [LANES*DW-1:0] nxt_d;
  logic [LANES*LG-1:0] nxt_r;

  for (genvar j = 0; j < LANES/2; j++) begin : g_sw
    localparam int LO = cq_pkg::pair_lo(j, STAGE);
    localparam int HI = LO + (1 << STAGE);
    logic a_up, a_dn, b_up, b_dn;
    assign a_up = in_v[LO] && !in_r[LO*LG + STAGE];
    assign a_dn = in_v[LO] &&  in_r[LO*LG + STAGE];
    assign b_up = in_v[HI] && !in_r[HI*LG + STAGE];
    assign b_dn = in_v[HI] &&  in_r[HI*LG + STAGE];

    assign nxt_v[LO] = a_up || b_up;
    assign nxt_v[HI] = a_dn || b_dn;
    assign nxt_d[LO*DW +: DW] = b_up ? in_d[HI*DW +: DW] : in_d[LO*DW +: DW];
    assign nxt_d[HI*DW +: DW] = a_dn ? in_d[LO*DW +: DW] : in_d[HI*DW +: DW];
    assign nxt_r[LO*LG +: LG] = b_up ? in_r[HI*LG +: LG] : in_r[LO*LG +: LG];
    assign nxt_r[HI*LG +: LG] = a_dn ? in_r[LO*LG +: LG] : in_r[HI*LG +: LG];
  end

  always_ff @(posedge clk) begin
    out_d <= nxt_d;
    out_r <= nxt_r;
    if (rst) begin
      out_v   <= '0;
      out_cnt <= '0;
    end else begin
      out_v   <= nxt_v;
      out_cnt <= in_cnt;
    end
  end

endmodule

// File: rtl/rank_compactor.sv
module rank_compactor #(
  parameter int LANES = 8,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          in_valid,
  input  logic [LANES*DW-1:0]       in_data,
  output logic [LANES-1:0]          out_valid,
  output logic [LANES*DW-1:0]       out_data,
  output logic [$clog2(LANES):0]    out_count
);

  localparam int LG = $clog2(LANES);
  localparam int CW = LG + 1;

  logic [LANES-1:0]    sv [LG+1];
  logic [LANES*DW-1:0] sd [LG+1];
  logic [LANES*LG-1:0] sr [LG+1];
  logic [CW-1:0]       sc [LG+1];

  cq_prefix_rank #(.LANES(LANES), .DW(DW), .LG(LG), .CW(CW)) u_rank (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .rank_valid (sv[0]),
    .rank_data  (sd[0]),
    .rank_idx   (sr[0]),
    .rank_count (sc[0])
  );

  for (genvar m = 0; m < LG; m++) begin : g_cube
    cq_cube_stage #(.LANES(LANES), .DW(DW), .LG(LG), .CW(CW), .STAGE(m)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .in_v    (sv[m]),
      .in_d    (sd[m]),
      .in_r    (sr[m]),
      .in_cnt  (sc[m]),
      .out_v   (sv[m+1]),
      .out_d   (sd[m+1]),
      .out_r   (sr[m+1]),
      .out_cnt (sc[m+1])
    );
  end

  assign out_valid = sv[LG];
  assign out_data  = sd[LG];
  assign out_count = sc[LG];

endmodule

// File: rtl/rank_compactor_chk.sv
module rank_compactor_chk #(
  parameter int LANES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       in_valid,
  input logic [LANES-1:0]       out_valid,
  input logic [$clog2(LANES):0] out_count
);

  localparam int LG  = $clog2(LANES);
  localparam int CW  = LG + 1;
  localparam int LAT = 2 * LG + 1;

  logic [CW-1:0] hist [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) hist[k] <= '0;
    end else begin
      hist[0] <= CW'($countones(in_valid));
      for (int k = 1; k < LAT; k++) hist[k] <= hist[k-1];
    end
  end

  AST_DENSE_LOW: assert property (@(posedge clk) disable iff (rst)
    ((out_valid + 1'b1) & out_valid) == '0);                                // R2

  AST_COUNT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) == int'(out_count));                               // R3

  AST_COUNT_DELAY: assert property (@(posedge clk) disable iff (rst)
    out_count == hist[LAT-1]);                                               // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && out_count == '0));                           // R7

endmodule

bind rank_compactor rank_compactor_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_count (out_count)
);

// File: tb/test_rank_compactor.sv
module test_rank_compactor;

  localparam int LANES  = 8;
  localparam int DW     = 8;
  localparam int LG     = $clog2(LANES);
  localparam int LAT    = 2 * LG + 1;
  localparam int CLK_NS = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [LANES-1:0]     in_valid = '0;
  logic [LANES*DW-1:0]  in_data  = '0;
  logic [LANES-1:0]     out_valid;
  logic [LANES*DW-1:0]  out_data;
  logic [LG:0]          out_count;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  rank_compactor #(.LANES(LANES), .DW(DW)) i_rank_compactor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_count(out_count)
  );

  task automatic note(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: stable compaction of valid lanes.
  task automatic compare(input string req, input logic [LANES-1:0] v,
                         input logic [LANES*DW-1:0] d);
    logic [LANES-1:0]    ev = '0;
    logic [LANES*DW-1:0] ed = '0;
    int k = 0;
    for (int i = 0; i < LANES; i++) begin
      if (v[i]) begin
        ev[k] = 1'b1;
        ed[k*DW +: DW] = d[i*DW +: DW];
        k++;
      end
    end
    note(out_valid == ev, {req, "/R2"}, "out_valid", out_valid, ev);
    note(int'(out_count) == k, {req, "/R3"}, "out_count", out_count, k);
    for (int i = 0; i < LANES; i++) begin
      if (ev[i])
        note(out_data[i*DW +: DW] == ed[i*DW +: DW], {req, "/R1"}, "lane data",
             out_data[i*DW +: DW], ed[i*DW +: DW]);
    end
  endtask

  function automatic logic [LANES*DW-1:0] mk_data(input int seed);
    logic [LANES*DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*DW +: DW] = DW'(seed * 37 + i * 11 + 5);
    return r;
  endfunction

  task automatic t_single(input string req, input logic [LANES-1:0] v, input int seed);
    logic [LANES*DW-1:0] d;
    d = mk_data(seed);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    @(negedge clk);
    in_valid = '0;
    in_data  = '0;
    repeat (LAT - 1) @(negedge clk);
    compare(req, v, d);
  endtask

  task automatic t_reset_state();
    note(out_valid == '0, "R7", "reset out_valid", out_valid, 0);
    note(out_count == '0, "R7", "reset out_count", out_count, 0);
  endtask

  // R4: back-to-back vectors, each checked exactly LAT cycles later.
  task automatic t_stream();
    localparam int S = 12;
    logic [LANES-1:0]    vs [S];
    logic [LANES*DW-1:0] ds [S];
    for (int s = 0; s < S; s++) begin
      vs[s] = LANES'((s * 73 + 29) ^ (s << 3));
      ds[s] = mk_data(100 + s);
    end
    for (int c = 0; c < S + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) compare("R4", vs[c-LAT], ds[c-LAT]);
      if (c < S) begin
        in_valid = vs[c];
        in_data  = ds[c];
      end else begin
        in_valid = '0;
        in_data  = '0;
      end
    end
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    in_valid = '1;
    in_data  = mk_data(7);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    in_valid = '0;
    @(negedge clk);
    note(out_valid == '0, "R7", "mid reset out_valid", out_valid, 0);
    note(out_count == '0, "R7", "mid reset out_count", out_count, 0);
    rst = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    note(out_valid == '0, "R7", "flushed out_valid", out_valid, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_single("R5", 8'b0000_0000, 1);
    t_single("R6", 8'b1111_1111, 2);
    t_single("R1", 8'b1010_0101, 3);
    t_single("R1", 8'b0101_1010, 4);
    t_single("R1", 8'b1000_0000, 5);
    t_single("R1", 8'b0000_0001, 6);
    t_single("R2", 8'b1110_0000, 8);
    t_single("R1", 8'b0111_1110, 9);
    t_single("R3", 8'b1101_1011, 10);
    t_stream();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule